// File: doc/BRIEF.md
# Countdown Timer with Shaped Interrupt Output

This block is a down-counting timer that runs from a 32.768 kHz base clock, one base period per `clk_i` cycle. A free-running divider chain makes five tick rates: 4096 Hz, 64 Hz, 1 Hz, one per minute and one per hour. A selected tick decrements an 8-bit counter. The counter holds its starting value in a reload register. When a tick finds the counter at one, the timer expires. It sets a sticky interrupt flag and starts an output pulse, and the counter takes the reload value again on that same tick.

The active-low output `int_no` works in one of two modes. In pulsed mode it goes low for a width chosen from the tick rate and the reload value. In level mode it stays low until software removes the cause. Software can end the output early in either mode, by clearing the flag or by dropping the interrupt enable. A reload value of zero halts the timer. All software access goes through one write port with three register addresses.

Top module: `cdt_pulse_gen`

## Requirements
- R1: After reset `int_no` is 1, `flag_o` is 0, the reload value is 0 and the timer is halted.
- R2: The address 0 register holds the interrupt enable in bit 0, the mode in bit 1 (1 = pulsed, 0 = level) and the source in bits 4:2. The source codes are 0 = 4096 Hz, 1 = 64 Hz, 2 = 1 Hz, 3 = per minute and 4 = per hour, and codes 5 to 7 give no ticks. With reload value n, successive expiries are n source periods apart. In base cycles a source period is 8, 512, 512*DIV_SEC, 512*DIV_SEC*DIV_MIN and 512*DIV_SEC*DIV_MIN*DIV_HR.
- R3: A write to address 1 loads both the reload register and the counter. At a tick with the counter at 1, the flag is set and the counter reloads.
- R4: While the counter is 0, no expiry occurs and the flag is not set. Writing a nonzero value to address 1 restarts the timer.
- R5: On the 4096 Hz source, the pulse is 4 base cycles long for n = 1 and 8 base cycles long for n > 1.
- R6: On the 64 Hz source, the pulse is 256 base cycles long.
- R7: On the 1 Hz, per-minute and per-hour sources, the pulse is 512 base cycles long.
- R8: In pulsed mode, writing 0 to bit 0 of address 2 during a pulse releases `int_no` on the next cycle.
- R9: In level mode, `int_no` stays low while the flag and the enable are both set. Clearing the enable releases it on the next cycle.
- R10: At address 2, a 0 in bit 0 clears the flag and a 1 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R11: With the enable at 0, the flag is still set on expiry and `int_no` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 32.768 kHz base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 reload, 2 flag |
| wr_data_i | input | 8 | Write data |
| flag_o | output | 1 | Sticky interrupt flag |
| int_no | output | 1 | Interrupt output, active low |

## Verification
The 4096 Hz source is tried with a reload of one and with random reloads from two to six. These runs separate the half-period pulse from the full-period pulse, and they confirm that the expiry spacing scales with n. The 64 Hz source and the three slow sources are each measured for pulse width and expiry spacing, which checks every stage of the divider chain. Directed cases cover the rest: a flag clear in the middle of a pulse, a clear that lands on an expiry cycle, a write of one to the flag, dropping the enable in level mode, an unused source code, and a reload of zero.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_SRC = 5;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_FLAG   = 2'd2;

  localparam logic [2:0] SRC_FAST = 3'd0;
  localparam logic [2:0] SRC_MID  = 3'd1;

  typedef struct packed {
    logic [2:0] src;
    logic       pulse;
    logic       ie;
  } ctrl_t;
endpackage

// File: rtl/cdt_div_stage.sv
module cdt_div_stage #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q;
  logic         last;

  assign last   = (cnt_q == W'(DIV - 1));
  assign tick_o = en_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end

  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= W'(DIV - 1)); // R2
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int DIV_FAST = 8,
  parameter int DIV_MID  = 64,
  parameter int DIV_SEC  = 64,
  parameter int DIV_MIN  = 60,
  parameter int DIV_HR   = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] src_i,
  output logic       tick_o
);
  localparam int NUM = cdt_pkg::NUM_SRC;
  localparam int DIVS [NUM] = '{DIV_FAST, DIV_MID, DIV_SEC, DIV_MIN, DIV_HR};

  logic [NUM-1:0] en, tick;
  logic [7:0]     tick_ext;

  for (genvar g = 0; g < NUM; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign en[g] = 1'b1;
    end else begin : g_next
      assign en[g] = tick[g-1];
    end
    cdt_div_stage #(.DIV(DIVS[g])) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en[g]),
      .tick_o(tick[g])
    );
  end

  // codes beyond the last stage select a constant zero
  assign tick_ext = 8'(tick);
  assign tick_o   = tick_ext[src_i];
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             clr_i,
  output logic             expire_o,
  output logic             reload_one_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic             flag_q;

  assign expire_o     = tick_i & (cnt_q == CNT_W'(1)) & ~ld_i;
  assign reload_one_o = (reload_q == CNT_W'(1));
  assign flag_o       = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (ld_i) begin
      reload_q <= ld_val_i;
      cnt_q    <= ld_val_i;
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= (cnt_q == CNT_W'(1)) ? reload_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire_o) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !ld_i) |=> (cnt_q == '0)); // R4
  AST_FLAG_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i && cnt_q == CNT_W'(1))); // R3
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == $past(reload_q))); // R3
  AST_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R10
endmodule

// File: rtl/cdt_pulse.sv
module cdt_pulse #(
  parameter int PW_FAST_ONE = 4,
  parameter int PW_FAST     = 8,
  parameter int PW_MID      = 256,
  parameter int PW_SLOW     = 512,
  parameter int PW_W        = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] src_i,
  input  logic       reload_one_i,
  output logic       active_o
);
  import cdt_pkg::*;

  logic [PW_W-1:0] pw_q, width;

  always_comb begin
    unique case (src_i)
      SRC_FAST: width = reload_one_i ? PW_W'(PW_FAST_ONE) : PW_W'(PW_FAST);
      SRC_MID:  width = PW_W'(PW_MID);
      default:  width = PW_W'(PW_SLOW);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pw_q <= '0;
    else if (start_i)       pw_q <= width;
    else if (pw_q != '0)    pw_q <= pw_q - 1'b1;
  end

  assign active_o = (pw_q != '0);

  AST_PW_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pw_q != '0 && !start_i) |=> (pw_q == $past(pw_q) - 1'b1)); // R5
  AST_PW_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pw_q != '0)); // R7
endmodule

// File: rtl/cdt_pulse_gen.sv
module cdt_pulse_gen
  import cdt_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int DIV_FAST = 8,
  parameter int DIV_MID  = 64,
  parameter int DIV_SEC  = 64,
  parameter int DIV_MIN  = 60,
  parameter int DIV_HR   = 60,
  parameter int PW_SLOW  = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              flag_o,
  output logic              int_no
);
  localparam int PW_FAST_ONE = DIV_FAST / 2;
  localparam int PW_FAST     = DIV_FAST;
  localparam int PW_MID      = DIV_FAST * DIV_MID / 2;
  localparam int PW_MAX      = (PW_SLOW > PW_MID) ? PW_SLOW : PW_MID;
  localparam int PW_W        = $clog2(PW_MAX + 1);

  ctrl_t ctrl_q;
  logic  wr_ctrl, wr_reload, flag_clr;
  logic  tick, expire, reload_one, pulse_act, flag;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_reload = wr_en_i && (wr_addr_i == ADDR_RELOAD);
  assign flag_clr  = wr_en_i && (wr_addr_i == ADDR_FLAG) && !wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data_i[$bits(ctrl_t)-1:0];
  end

  cdt_prescaler #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SEC(DIV_SEC),
    .DIV_MIN(DIV_MIN), .DIV_HR(DIV_HR)
  ) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (ctrl_q.src),
    .tick_o(tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .ld_i        (wr_reload),
    .ld_val_i    (wr_data_i[CNT_W-1:0]),
    .clr_i       (flag_clr),
    .expire_o    (expire),
    .reload_one_o(reload_one),
    .flag_o      (flag)
  );

  cdt_pulse #(
    .PW_FAST_ONE(PW_FAST_ONE), .PW_FAST(PW_FAST), .PW_MID(PW_MID),
    .PW_SLOW(PW_SLOW), .PW_W(PW_W)
  ) u_pulse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (expire),
    .src_i       (ctrl_q.src),
    .reload_one_i(reload_one),
    .active_o    (pulse_act)
  );

  // pulse gated by the flag so a clear cuts it short
  assign int_no = ~(flag & ctrl_q.ie & (pulse_act | ~ctrl_q.pulse));
  assign flag_o = flag;

  AST_CLR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr && !expire) |=> int_no); // R8
  AST_IE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !wr_data_i[0]) |=> int_no); // R9
  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.pulse && ctrl_q.ie && flag && !wr_en_i) |=> !int_no); // R9
endmodule

// File: tb/tb_cdt_pulse_gen.sv
module tb_cdt_pulse_gen;
  localparam int DIV_SEC = 4;
  localparam int DIV_MIN = 2;
  localparam int DIV_HR  = 2;
  localparam int TMO     = 40000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       flag, int_n;
  int         errors = 0, checks = 0;
  longint     cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cdt_pulse_gen #(.DIV_SEC(DIV_SEC), .DIV_MIN(DIV_MIN), .DIV_HR(DIV_HR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .flag_o(flag), .int_no(int_n)
  );

  function automatic int exp_period(int src, int n);
    int p;
    case (src)
      0: p = 8;
      1: p = 512;
      2: p = 512 * DIV_SEC;
      3: p = 512 * DIV_SEC * DIV_MIN;
      default: p = 512 * DIV_SEC * DIV_MIN * DIV_HR;
    endcase
    return p * n;
  endfunction

  function automatic int exp_width(int src, int n);
    if (src == 0) return (n == 1) ? 4 : 8;
    if (src == 1) return 256;
    return 512;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(int src, bit pulse, bit ie);
    return {3'b000, 3'(src), pulse, ie};
  endfunction

  task automatic wait_fall(output bit found, output longint t, input int limit);
    found = 1'b0;
    t = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!int_n) begin found = 1'b1; t = cyc; break; end
    end
  endtask

  task automatic low_len(output int w);
    w = 0;
    while (!int_n && w < 100000) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic measure(int src, int n, string tag);
    bit f1, f2;
    longint t1, t2;
    int w;
    wr(2'd0, ctrl(src, 1'b1, 1'b1));
    wr(2'd1, 8'(n));
    wr(2'd2, 8'h00);
    wait_fall(f1, t1, TMO);
    chk(f1, {tag, " first expiry"}, f1, 1);
    low_len(w);
    chk(w == exp_width(src, n), {tag, " width"}, w, exp_width(src, n));
    wait_fall(f2, t2, TMO);
    chk(f2 && (t2 - t1 == exp_period(src, n)), {tag, " period"}, t2 - t1, exp_period(src, n));
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit f;
    longint t;
    int w, n;
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(int_n == 1'b1, "R1 int_no", int_n, 1);
    chk(flag == 1'b0, "R1 flag", flag, 0);
    wr(2'd0, ctrl(0, 1'b1, 1'b1));
    wait_fall(f, t, 600);
    chk(!f && !flag, "R1 halted after reset", f, 0);

    // R5, R2: fast source
    measure(0, 1, "R5 fast n=1");
    measure(0, 2, "R5 fast n=2");
    for (int k = 0; k < 4; k++) begin
      n = 2 + int'($urandom % 5);
      measure(0, n, "R2 fast random");
    end
    // R6, R7
    measure(1, 1, "R6 mid n=1");
    for (int k = 0; k < 2; k++) begin
      n = 1 + int'($urandom % 2);
      measure(1, n, "R6 mid random");
    end
    measure(2, 1, "R7 sec");
    measure(3, 1, "R7 min");
    measure(4, 1, "R7 hour");

    // R2: unused source code gives no ticks
    wr(2'd0, ctrl(5, 1'b1, 1'b1));
    wr(2'd1, 8'd1);
    wr(2'd2, 8'h00);
    wait_fall(f, t, 3000);
    chk(!f && !flag, "R2 code 5 silent", flag, 0);

    // R4: zero reload halts, nonzero restarts
    wr(2'd0, ctrl(0, 1'b1, 1'b1));
    wr(2'd1, 8'd0);
    wr(2'd2, 8'h00);
    wait_fall(f, t, 200);
    chk(!f && !flag, "R4 zero reload halted", flag, 0);
    wr(2'd1, 8'd2);
    wait_fall(f, t, 40);
    chk(f && flag, "R4 restart after nonzero reload", flag, 1);

    // R8: early clear in pulsed mode
    wr(2'd0, ctrl(1, 1'b1, 1'b1));
    wr(2'd1, 8'd1);
    wr(2'd2, 8'h00);
    wait_fall(f, t, TMO);
    repeat (10) @(negedge clk);
    chk(int_n == 1'b0, "R8 pulse still low before clear", int_n, 0);
    wr(2'd2, 8'h00);
    chk(int_n == 1'b1, "R8 release after flag clear", int_n, 1);
    repeat (200) @(negedge clk);
    chk(int_n == 1'b1, "R8 stays released", int_n, 1);

    // R10: write of 1 keeps flag
    wait_fall(f, t, TMO);
    wr(2'd2, 8'h01);
    chk(flag == 1'b1, "R10 write 1 ignored", flag, 1);

    // R10: clear works between expiries, loses against an expiry
    wr(2'd0, ctrl(0, 1'b1, 1'b1));
    wr(2'd1, 8'd1);
    wait_fall(f, t, 100);
    while (!int_n) @(negedge clk);
    wait_fall(f, t, 100);
    repeat (3) @(negedge clk);
    wr(2'd2, 8'h00);
    chk(flag == 1'b0, "R10 clear between expiries", flag, 0);
    repeat (3) @(negedge clk);
    wr(2'd2, 8'h00);
    chk(flag == 1'b1, "R10 expiry beats clear", flag, 1);

    // R9, R11: level mode
    wr(2'd0, ctrl(1, 1'b0, 1'b1));
    wr(2'd1, 8'd1);
    wr(2'd2, 8'h00);
    wait_fall(f, t, TMO);
    repeat (300) @(negedge clk);
    chk(int_n == 1'b0, "R9 level held past pulse width", int_n, 0);
    wr(2'd0, ctrl(1, 1'b0, 1'b0));
    chk(int_n == 1'b1, "R9 release on enable clear", int_n, 1);
    wr(2'd2, 8'h00);
    repeat (600) @(negedge clk);
    chk(flag == 1'b1, "R11 flag set with enable off", flag, 1);
    chk(int_n == 1'b1, "R11 output quiet with enable off", int_n, 1);
    wr(2'd1, 8'd0);
    wr(2'd0, ctrl(1, 1'b0, 1'b1));
    chk(int_n == 1'b0, "R9 low again on enable", int_n, 0);
    wr(2'd2, 8'h00);
    chk(int_n == 1'b1, "R9 release on flag clear", int_n, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule